// File: doc/BRIEF.md
# Interrupt Priority and Vector Resolver

This block gathers every interrupt request a CPU core can see. It removes the ones that are masked and chooses exactly one winner. It then hands the core that winner's identity and the address from which the core fetches the service-routine pointer.

There are three groups of requests:
- Ordinary peripheral sources, each with its own enable bit. The whole group is also gated by the core's I mask bit.
- An active-low external IRQ pin. It belongs to the maskable group and can work in level mode or in latched falling-edge mode.
- A high-priority XIRQ request, gated only by a one-way X mask held inside the block, plus four traps that nothing can mask: software interrupt, illegal opcode, watchdog timeout and clock-loss.

Inside the maskable group, one source chosen by software can be raised to the top. The IRQ pin mode can only be written during a short window after reset.

Each vector entry is two bytes wide. Source number `k` fetches from `VEC_BASE + 2*k`. The numbers are ordered as follows:
- Peripherals take 0 to N_PERIPH-1.
- IRQ is N_PERIPH.
- XIRQ is N_PERIPH+1.
- The traps follow in rising priority: software interrupt, illegal opcode, watchdog, clock-loss.

With the defaults, the table runs from 0xFFD6 to 0xFFFC. The outputs are registered, so they reflect the inputs present at the previous clock edge.

Top module: `irq_vector_resolver`

## Requirements
- R1: After reset, `pend_o` is 0, `win_id_o` and `vec_o` are 0, and `x_mask_o` is 1. IRQ is the promoted source and the pin works in level mode.
- R2: Peripheral source k is a candidate only when `periph_req_i[k]` and `periph_en_i[k]` are both 1 and `imask_i` is 0. The IRQ pin is a candidate only when `imask_i` is 0.
- R3: XIRQ is a candidate whenever `xirq_req_i` is 1 and `x_mask_o` is 0, whatever the value of `imask_i`. It wins over every maskable candidate.
- R4: `x_clr_i` clears `x_mask_o` on the next edge, and no input sets it except one. An acknowledge (`ack_i`=1) with `ack_id_i` equal to the XIRQ number sets it on the next edge, and this set wins over a simultaneous clear.
- R5: A trap bit in `trap_req_i` always produces a winner. Bit 3 (clock-loss) beats bit 2 (watchdog), bit 2 beats bit 1 (illegal opcode), and bit 1 beats bit 0 (software interrupt). Any trap beats XIRQ. Bit t has number N_PERIPH+2+t.
- R6: Within the maskable group, the promoted source wins if it is a candidate. Otherwise the candidate with the highest number wins.
- R7: Writing to the promote register (`promote_wr_i`) with a value from 0 to N_PERIPH takes effect at the next edge. A value above N_PERIPH is ignored.
- R8: The outputs reflect the inputs present at the previous edge. When `pend_o` is 1, `vec_o` equals `VEC_BASE + 2*win_id_o`. When `pend_o` is 0, both `win_id_o` and `vec_o` are 0.
- R9: In level mode, IRQ is requested exactly while `irq_n_i` is 0.
- R10: In edge mode, a 1-to-0 transition of `irq_n_i` sets a latch and IRQ is pending from the second edge after the fall. The latch holds after the pin returns high and is cleared by an acknowledge whose `ack_id_i` is the IRQ number.
- R11: `mode_wr_i` loads `mode_edge_i` into the mode bit only at the first CFG_WINDOW clock edges after reset release. Later writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_req_i | input | N_PERIPH | Peripheral request lines |
| periph_en_i | input | N_PERIPH | Per-peripheral enable bits |
| irq_n_i | input | 1 | External IRQ pin, active low, synchronous to clk |
| xirq_req_i | input | 1 | XIRQ request |
| trap_req_i | input | 4 | Unmaskable traps: 0 software interrupt, 1 illegal opcode, 2 watchdog, 3 clock-loss |
| imask_i | input | 1 | Core I mask bit |
| x_clr_i | input | 1 | Software clear of the X mask |
| promote_wr_i | input | 1 | Promote register write strobe |
| promote_val_i | input | ID_W | Source number to promote |
| mode_wr_i | input | 1 | IRQ mode write strobe |
| mode_edge_i | input | 1 | 1 selects falling-edge mode |
| ack_i | input | 1 | Core acknowledges a taken interrupt |
| ack_id_i | input | ID_W | Number of the acknowledged source |
| pend_o | output | 1 | A winner exists |
| win_id_o | output | ID_W | Winning source number |
| vec_o | output | 16 | Vector fetch address of the winner |
| x_mask_o | output | 1 | Current X mask |

## Verification
The bench builds the block with six peripherals, `VEC_BASE` = 0xFFE6 and a write window of eight cycles. With these values the table still ends at 0xFFFC.

Because the maskable group shrinks to seven sources, the bench can sweep every promote setting against every pair of simultaneous maskable requests, all sixteen trap combinations, and every masking combination of each single source. The short window lets the bench hit both the last cycle in which a mode write is accepted and the first cycle in which one is refused.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Number of unmaskable trap inputs, lowest priority first.
    localparam int N_TRAP = 4;

    // Two-byte vector entry for a source number.
    function automatic logic [15:0] vec_of(input logic [15:0] base, input logic [7:0] id);
        return base + {7'b0, id, 1'b0};
    endfunction

endpackage

// File: rtl/irq_pin_ctl.sv
// IRQ pin front end: level or latched falling-edge request, with a mode bit
// that can be written only during a window after reset.
module irq_pin_ctl #(
    parameter int CFG_WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    input  logic cfg_wr_i,
    input  logic cfg_edge_i,
    input  logic ack_clr_i,
    output logic irq_act_o
);
    localparam int CW = $clog2(CFG_WINDOW + 1);

    typedef struct packed {
        logic          prev;
        logic          latch;
        logic          edge_mode;
        logic [CW-1:0] cnt;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    open_w;
    logic    fall_w;

    always_comb begin
        st_d   = st_q;
        open_w = (st_q.cnt < CW'(CFG_WINDOW));
        fall_w = st_q.prev & ~irq_n_i;
        if (open_w) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (cfg_wr_i) begin
                st_d.edge_mode = cfg_edge_i;
            end
        end
        st_d.prev = irq_n_i;
        if (!st_q.edge_mode) begin
            st_d.latch = 1'b0;
        end else if (fall_w) begin
            st_d.latch = 1'b1;
        end else if (ack_clr_i) begin
            st_d.latch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, latch: 1'b0, edge_mode: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_act_o = st_q.edge_mode ? st_q.latch : ~irq_n_i;

endmodule

// File: rtl/irq_mask_prio.sv
// Maskable group: per-source and global masking, promoted-source override,
// otherwise highest number wins.
module irq_mask_prio #(
    parameter int N_PERIPH = 14,
    parameter int ID_W     = 5
) (
    input  logic [N_PERIPH-1:0] periph_req_i,
    input  logic [N_PERIPH-1:0] periph_en_i,
    input  logic                irq_act_i,
    input  logic                imask_i,
    input  logic [ID_W-1:0]     promote_i,
    output logic                valid_o,
    output logic [ID_W-1:0]     id_o
);
    localparam int NM = N_PERIPH + 1;

    logic [NM-1:0] elig;

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_elig
        assign elig[g] = periph_req_i[g] & periph_en_i[g] & ~imask_i;
    end
    assign elig[N_PERIPH] = irq_act_i & ~imask_i;

    logic            promo_hit;
    logic [ID_W-1:0] high_id;

    always_comb begin
        high_id   = '0;
        promo_hit = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (elig[i]) begin
                high_id = ID_W'(i);
                if (promote_i == ID_W'(i)) begin
                    promo_hit = 1'b1;
                end
            end
        end
    end

    assign valid_o = |elig;
    assign id_o    = promo_hit ? promote_i : high_id;

endmodule

// File: rtl/irq_vector_resolver.sv
// Top: trap and XIRQ arbitration over the maskable group, X mask, promote
// register, and registered winner/vector outputs.
module irq_vector_resolver #(
    parameter int          N_PERIPH   = 14,
    parameter logic [15:0] VEC_BASE   = 16'hFFD6,
    parameter int          CFG_WINDOW = 64,
    localparam int         NSRC       = N_PERIPH + 2 + irq_res_pkg::N_TRAP,
    localparam int         ID_W       = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] periph_req_i,
    input  logic [N_PERIPH-1:0] periph_en_i,
    input  logic                irq_n_i,
    input  logic                xirq_req_i,
    input  logic [3:0]          trap_req_i,
    input  logic                imask_i,
    input  logic                x_clr_i,
    input  logic                promote_wr_i,
    input  logic [ID_W-1:0]     promote_val_i,
    input  logic                mode_wr_i,
    input  logic                mode_edge_i,
    input  logic                ack_i,
    input  logic [ID_W-1:0]     ack_id_i,
    output logic                pend_o,
    output logic [ID_W-1:0]     win_id_o,
    output logic [15:0]         vec_o,
    output logic                x_mask_o
);
    import irq_res_pkg::*;

    localparam int ID_IRQ   = N_PERIPH;
    localparam int ID_XIRQ  = N_PERIPH + 1;
    localparam int ID_TRAP0 = N_PERIPH + 2;

    typedef struct packed {
        logic            x_mask;
        logic [ID_W-1:0] promote;
        logic            pend;
        logic [ID_W-1:0] win_id;
        logic [15:0]     vec;
    } top_st_t;

    top_st_t st_d, st_q;

    logic            ack_irq, ack_xirq;
    logic            irq_act;
    logic            m_valid;
    logic [ID_W-1:0] m_id;

    assign ack_irq  = ack_i && (ack_id_i == ID_W'(ID_IRQ));
    assign ack_xirq = ack_i && (ack_id_i == ID_W'(ID_XIRQ));

    irq_pin_ctl #(.CFG_WINDOW(CFG_WINDOW)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n_i   (irq_n_i),
        .cfg_wr_i  (mode_wr_i),
        .cfg_edge_i(mode_edge_i),
        .ack_clr_i (ack_irq),
        .irq_act_o (irq_act)
    );

    irq_mask_prio #(.N_PERIPH(N_PERIPH), .ID_W(ID_W)) u_prio (
        .periph_req_i(periph_req_i),
        .periph_en_i (periph_en_i),
        .irq_act_i   (irq_act),
        .imask_i     (imask_i),
        .promote_i   (st_q.promote),
        .valid_o     (m_valid),
        .id_o        (m_id)
    );

    logic            hit;
    logic [ID_W-1:0] sel_id;

    always_comb begin
        st_d = st_q;

        // One-way X mask: software may only clear, an XIRQ acknowledge sets.
        if (x_clr_i) begin
            st_d.x_mask = 1'b0;
        end
        if (ack_xirq) begin
            st_d.x_mask = 1'b1;
        end

        if (promote_wr_i && (promote_val_i <= ID_W'(ID_IRQ))) begin
            st_d.promote = promote_val_i;
        end

        hit    = 1'b0;
        sel_id = '0;
        for (int t = 0; t < N_TRAP; t++) begin
            if (trap_req_i[t]) begin
                hit    = 1'b1;
                sel_id = ID_W'(ID_TRAP0 + t);
            end
        end
        if (!hit && xirq_req_i && !st_q.x_mask) begin
            hit    = 1'b1;
            sel_id = ID_W'(ID_XIRQ);
        end
        if (!hit && m_valid) begin
            hit    = 1'b1;
            sel_id = m_id;
        end

        st_d.pend   = hit;
        st_d.win_id = hit ? sel_id : '0;
        st_d.vec    = hit ? vec_of(VEC_BASE, 8'(sel_id)) : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{x_mask: 1'b1, promote: ID_W'(ID_IRQ), pend: 1'b0,
                      win_id: '0, vec: 16'h0000};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o   = st_q.pend;
    assign win_id_o = st_q.win_id;
    assign vec_o    = st_q.vec;
    assign x_mask_o = st_q.x_mask;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int          N_PERIPH   = 14,
    parameter logic [15:0] VEC_BASE   = 16'hFFD6,
    parameter int          CFG_WINDOW = 64,
    localparam int         NSRC       = N_PERIPH + 2 + irq_res_pkg::N_TRAP,
    localparam int         ID_W       = $clog2(NSRC)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                xirq_req_i,
    input logic [3:0]          trap_req_i,
    input logic                imask_i,
    input logic                x_clr_i,
    input logic                ack_i,
    input logic [ID_W-1:0]     ack_id_i,
    input logic                pend_o,
    input logic [ID_W-1:0]     win_id_o,
    input logic [15:0]         vec_o,
    input logic                x_mask_o
);
    localparam logic [ID_W-1:0] XID = ID_W'(N_PERIPH + 1);
    localparam logic [ID_W-1:0] TID = ID_W'(N_PERIPH + 2);

    a_r8_vector_address: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (vec_o == VEC_BASE + 16'(win_id_o) * 16'd2));

    a_r8_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_o |-> (win_id_o == '0 && vec_o == 16'h0000));

    a_r4_x_set_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask_o) |-> $past(ack_i && ack_id_i == XID));

    a_r4_x_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (x_clr_i && !(ack_i && ack_id_i == XID)) |=> !x_mask_o);

    a_r5_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_i != 4'b0) |=> (pend_o && win_id_o >= TID));

    a_r3_xirq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xirq_req_i && !x_mask_o && trap_req_i == 4'b0) |=> (pend_o && win_id_o == XID));

    a_r2_imask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_i && trap_req_i == 4'b0 && !(xirq_req_i && !x_mask_o)) |=> !pend_o);

endmodule

bind irq_vector_resolver irq_resolver_chk #(
    .N_PERIPH(N_PERIPH), .VEC_BASE(VEC_BASE), .CFG_WINDOW(CFG_WINDOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xirq_req_i(xirq_req_i), .trap_req_i(trap_req_i),
    .imask_i(imask_i), .x_clr_i(x_clr_i), .ack_i(ack_i), .ack_id_i(ack_id_i),
    .pend_o(pend_o), .win_id_o(win_id_o), .vec_o(vec_o), .x_mask_o(x_mask_o)
);

// File: tb/sim_irq_vector_resolver.sv
`timescale 1ns/1ps
module sim_irq_vector_resolver;
    localparam int          NP   = 6;
    localparam logic [15:0] BASE = 16'hFFE6;
    localparam int          WIN  = 8;
    localparam int          IDW  = 4;
    localparam int          IRQ  = NP;
    localparam int          XIRQ = NP + 1;
    localparam int          TRP0 = NP + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] periph_req = '0, periph_en = '0;
    logic irq_n = 1'b1, xirq_req = 1'b0, imask = 1'b0, x_clr = 1'b0;
    logic [3:0] trap_req = '0;
    logic promote_wr = 1'b0, mode_wr = 1'b0, mode_edge = 1'b0, ack = 1'b0;
    logic [IDW-1:0] promote_val = '0, ack_id = '0;
    logic pend, x_mask;
    logic [IDW-1:0] win_id;
    logic [15:0] vec;

    int n_chk = 0, n_fail = 0;
    int m_promote = IRQ;
    bit m_xmask = 1'b1;

    always #10 clk = ~clk;

    irq_vector_resolver #(.N_PERIPH(NP), .VEC_BASE(BASE), .CFG_WINDOW(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .periph_req_i(periph_req), .periph_en_i(periph_en),
        .irq_n_i(irq_n), .xirq_req_i(xirq_req), .trap_req_i(trap_req), .imask_i(imask),
        .x_clr_i(x_clr), .promote_wr_i(promote_wr), .promote_val_i(promote_val),
        .mode_wr_i(mode_wr), .mode_edge_i(mode_edge), .ack_i(ack), .ack_id_i(ack_id),
        .pend_o(pend), .win_id_o(win_id), .vec_o(vec), .x_mask_o(x_mask)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reference winner from the requirements, level mode; -1 means none.
    function automatic int ref_win(input bit irq_act);
        bit [NP:0] el;
        for (int t = 3; t >= 0; t--) if (trap_req[t]) return TRP0 + t;
        if (xirq_req && !m_xmask) return XIRQ;
        if (imask) return -1;
        el = {irq_act, periph_req & periph_en};
        if (m_promote <= NP && el[m_promote]) return m_promote;
        for (int i = NP; i >= 0; i--) if (el[i]) return i;
        return -1;
    endfunction

    task automatic check_out(input string req, input int exp);
        logic [15:0] ev;
        n_chk++;
        ev = (exp < 0) ? 16'h0 : BASE + 16'(exp) * 16'd2;
        if (exp < 0) begin
            if (pend !== 1'b0 || win_id !== '0 || vec !== 16'h0) begin
                n_fail++;
                $display("FAIL %s: pend=%0b id=%0d vec=%h expected pend=0 id=0 vec=0000",
                         req, pend, win_id, vec);
            end
        end else if (pend !== 1'b1 || win_id !== IDW'(exp) || vec !== ev) begin
            n_fail++;
            $display("FAIL %s: pend=%0b id=%0d vec=%h expected pend=1 id=%0d vec=%h",
                     req, pend, win_id, vec, exp, ev);
        end
    endtask

    task automatic check_x(input string req, input bit exp);
        n_chk++;
        if (x_mask !== exp) begin
            n_fail++;
            $display("FAIL %s: x_mask=%0b expected %0b", req, x_mask, exp);
        end
    endtask

    task automatic do_reset();
        periph_req = '0; periph_en = '0; irq_n = 1'b1; xirq_req = 1'b0;
        imask = 1'b0; x_clr = 1'b0; trap_req = '0; promote_wr = 1'b0;
        mode_wr = 1'b0; mode_edge = 1'b0; ack = 1'b0;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        m_promote = IRQ; m_xmask = 1'b1;
    endtask

    task automatic set_promote(input int p);
        promote_wr = 1'b1; promote_val = IDW'(p);
        tick();
        promote_wr = 1'b0;
        if (p <= NP) m_promote = p;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check_out("R1 reset outputs", -1);
        check_x("R1 reset x mask", 1'b1);
        // R1 / R9: level mode after reset
        irq_n = 1'b0; tick(); check_out("R9 level low", IRQ);
        irq_n = 1'b1; tick(); check_out("R1 R9 level released", -1);

        // R2: each single source under every mask combination
        for (int i = 0; i < NP; i++)
            for (int e = 0; e < 2; e++)
                for (int m = 0; m < 2; m++) begin
                    periph_req = '0; periph_req[i] = 1'b1;
                    periph_en = e[0] ? '1 : '0; imask = m[0];
                    tick();
                    check_out("R2 single source masking", ref_win(1'b0));
                end
        imask = 1'b1; irq_n = 1'b0; periph_req = '0; tick();
        check_out("R2 imask blocks IRQ", -1);
        irq_n = 1'b1; imask = 1'b0; periph_en = '1;

        // R6: every promote value against every pair of maskable requests
        for (int p = 0; p <= NP; p++) begin
            set_promote(p);
            for (int a = 0; a <= NP; a++)
                for (int b = 0; b <= NP; b++) begin
                    periph_req = '0;
                    if (a < NP) periph_req[a] = 1'b1;
                    if (b < NP) periph_req[b] = 1'b1;
                    irq_n = !(a == NP || b == NP);
                    tick();
                    check_out("R6 promoted pair", ref_win(!irq_n));
                end
        end
        irq_n = 1'b1;

        // R7: out-of-range promote values are ignored
        set_promote(2);
        for (int v = NP + 1; v < 16; v++) set_promote(v);
        periph_req = '0; periph_req[2] = 1'b1; periph_req[5] = 1'b1; tick();
        check_out("R7 invalid promote ignored", 2);
        periph_req = '0; periph_req[3] = 1'b1; tick();
        check_out("R7 fallback highest", 3);

        // R3 / R4: XIRQ and the one-way X mask
        periph_req = '1; imask = 1'b1; xirq_req = 1'b1; tick();
        check_out("R3 XIRQ blocked by X", -1);
        x_clr = 1'b1; tick(); x_clr = 1'b0; m_xmask = 1'b0;
        check_x("R4 x cleared", 1'b0);
        tick(); check_out("R3 XIRQ ignores imask", XIRQ);
        imask = 1'b0; tick(); check_out("R3 XIRQ beats maskable", XIRQ);
        ack = 1'b1; ack_id = IDW'(XIRQ); x_clr = 1'b1; tick();
        ack = 1'b0; x_clr = 1'b0; m_xmask = 1'b1;
        check_x("R4 ack sets x over clear", 1'b1);
        imask = 1'b1; tick(); check_out("R4 nested XIRQ blocked", -1);
        x_clr = 1'b1; tick(); x_clr = 1'b0; m_xmask = 1'b0;

        // R5: all trap combinations over XIRQ and maskable requests
        imask = 1'b0;
        for (int tv = 0; tv < 16; tv++) begin
            trap_req = 4'(tv); tick();
            check_out("R5 trap priority", ref_win(1'b0));
        end
        trap_req = '0; xirq_req = 1'b0; periph_req = '0;

        // R8 idle
        tick(); check_out("R8 nothing pending", -1);

        // R10 / R11: mode written at the last edge of the window
        do_reset();
        for (int k = 0; k < WIN - 1; k++) tick();
        mode_wr = 1'b1; mode_edge = 1'b1; tick(); mode_wr = 1'b0;
        irq_n = 1'b0; tick(); check_out("R10 edge not yet visible", -1);
        irq_n = 1'b1; tick(); check_out("R11 R10 latched edge", IRQ);
        tick(); check_out("R10 latch holds", IRQ);
        ack = 1'b1; ack_id = IDW'(IRQ); tick(); ack = 1'b0;
        tick(); check_out("R10 ack clears latch", -1);

        // R11: a write one edge late is refused
        do_reset();
        for (int k = 0; k < WIN; k++) tick();
        mode_wr = 1'b1; mode_edge = 1'b1; tick(); mode_wr = 1'b0;
        irq_n = 1'b0; tick(); check_out("R11 still level low", IRQ);
        irq_n = 1'b1; tick(); check_out("R11 late write ignored", -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule